// File: doc/BRIEF.md
# Interlocked Read Link over a Multiplexed Bus

Two controllers carry a single-word read across a shared 32-bit bus whose lines hold an address in the first half of a transaction and read data in the second half. A requester controller and a memory-side controller each run on their own clock, and no clock is shared between them. Three control lines tie them together: a read strobe owned by the requester, a data-ready strobe owned by the memory side, and one acknowledge line. The acknowledge line is the OR of one acknowledge driver on each side. Each controller moves forward only when it sees the other side's control lines change. Those lines are first passed through a synchroniser of at least two flops.

A local client pulses `start_i` with an address. The requester raises the read strobe and drives the address at the same moment. The memory side latches the address, acknowledges, and starts its access. The requester then drops the strobe and releases the lines, and the memory side drops its acknowledge. When the access time has run out, the memory side raises data-ready and drives the word it read. The requester latches the word and acknowledges. The memory side then drops data-ready and releases the lines. Last, the requester drops its acknowledge and pulses `done_o`.

Top module: `hsb_read_link`

## Requirements
- R1: While reset is held and after it is released, the read strobe, data-ready and acknowledge are low, `busy_o` and `done_o` are low, and the bus reads zero.
- R2: A `start_i` pulse accepted in idle raises `busy_o` and the read strobe on the same requester clock edge, and the bus carries `addr_i` from that edge onward.
- R3: The read strobe stays high until the requester has seen acknowledge. It falls together with the release of the address, after which the bus reads zero.
- R4: The memory side raises acknowledge only after it sees the read strobe, with the captured address presented on `mem_addr_o`. It keeps acknowledge high until it sees the strobe low.
- R5: Data-ready rises only after acknowledge has fallen and at least ACC_CYC memory clocks after the address was captured. It comes with the bus carrying `mem_rdata_i` for the captured address, and it stays high with stable data until the requester's acknowledge is seen.
- R6: The eight control edges of one read occur strictly in this order: strobe up, ack up, strobe down, ack down, ready up, ack up, ready down, ack down. After the last edge `done_o` pulses for one cycle and `rdata_o` holds the word that was read.
- R7: Each side drives the bus only while its own strobe is high. The two sides never drive it at the same time, and undriven lines read as zero.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the running read nor its result, and it starts no second read.
- R9: A `start_i` pulse in idle is ignored while any control line the requester observes through its synchroniser is still high. This includes the cycle right after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Requester-side clock |
| clk_mem | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| start_i | input | 1 | One-cycle read request from the local client |
| addr_i | input | 32 | Address for the read, sampled with `start_i` |
| busy_o | output | 1 | Requester has a read in flight |
| done_o | output | 1 | One-cycle pulse when the read has finished |
| rdata_o | output | 32 | Word returned by the last read |
| mem_addr_o | output | 32 | Address captured by the memory side |
| mem_rdata_i | input | 32 | Memory array contents at `mem_addr_o` |
| readreq_o | output | 1 | Read strobe line |
| datardy_o | output | 1 | Data-ready line |
| ack_o | output | 1 | Shared acknowledge line |
| bus_o | output | 32 | Multiplexed address/data lines |

## Verification
Reads are issued with random addresses and random idle gaps, plus the all-zero and all-one addresses. The all-zero and all-one cases show that address and data truly take turns on the same lines. A separate monitor watches every edge of the three control lines and compares each one with its place in the eight-step order. When the strobes rise and fall it also checks what the bus carries, which separates a correct interlock from one that merely finishes. Two directed cases test the start gating. One pulses `start_i` in the middle of a read. The other pulses it on the cycle right after `done_o`, while the requester's own acknowledge is still in its synchroniser.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [2:0] {
    R_IDLE,
    R_ADDR,
    R_RELEASE,
    R_WAIT_DATA,
    R_ACK
  } req_state_e;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ACK,
    M_ACCESS,
    M_DATA,
    M_DONE
  } mem_state_e;

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsb_rst_sync.sv
module hsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_o = sh_q[1];
endmodule

// File: rtl/hsb_requester.sv
module hsb_requester
  import hsb_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] bus_i,
  input  logic          ack_line_i,
  input  logic          rdy_line_i,
  output logic          req_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] drv_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  logic [1:0] ctl_s;
  logic       ack_s, rdy_s;

  hsb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({rdy_line_i, ack_line_i}),
    .q_o   (ctl_s)
  );
  assign ack_s = ctl_s[0];
  assign rdy_s = ctl_s[1];

  req_state_e    st_q, st_d;
  logic          req_q, ack_q, oe_q, done_q;
  logic [DW-1:0] addr_q, rdata_q;
  logic          addr_en, rdata_en;

  // next state
  always_comb begin
    st_d     = st_q;
    addr_en  = 1'b0;
    rdata_en = 1'b0;
    unique case (st_q)
      R_IDLE: begin
        if (start_i && !ack_s && !rdy_s) begin
          st_d    = R_ADDR;
          addr_en = 1'b1;
        end
      end
      R_ADDR:      if (ack_s)  st_d = R_RELEASE;
      R_RELEASE:   if (!ack_s) st_d = R_WAIT_DATA;
      R_WAIT_DATA: begin
        if (rdy_s) begin
          st_d     = R_ACK;
          rdata_en = 1'b1;
        end
      end
      R_ACK:       if (!rdy_s) st_d = R_IDLE;
      default:     st_d = R_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= R_IDLE;
      req_q  <= 1'b0;
      oe_q   <= 1'b0;
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= (st_d == R_ADDR);
      oe_q   <= (st_d == R_ADDR);
      ack_q  <= (st_d == R_ACK);
      done_q <= (st_q == R_ACK) && (st_d == R_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= bus_i;
  end

  assign req_o   = req_q;
  assign ack_o   = ack_q;
  assign oe_o    = oe_q;
  assign drv_o   = addr_q;
  assign busy_o  = (st_q != R_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack_s |=> req_q); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && $past(req_q) |-> $stable(drv_o)); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!ack_s && !rdy_s)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
endmodule

// File: rtl/hsb_memside.sv
module hsb_memside
  import hsb_pkg::*;
#(
  parameter int DW          = 32,
  parameter int ACC_CYC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_i,
  input  logic          req_line_i,
  input  logic          ack_line_i,
  output logic          rdy_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] drv_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int CW = $clog2(ACC_CYC + 1);

  logic [1:0] ctl_s;
  logic       req_s, ack_s;

  hsb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ack_line_i, req_line_i}),
    .q_o   (ctl_s)
  );
  assign req_s = ctl_s[0];
  assign ack_s = ctl_s[1];

  mem_state_e    st_q, st_d;
  logic          rdy_q, ack_q, oe_q;
  logic [DW-1:0] maddr_q, data_q;
  logic [CW-1:0] cnt_q;
  logic          cap_en, data_en;

  // next state
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    data_en = 1'b0;
    unique case (st_q)
      M_IDLE: begin
        if (req_s && !ack_s) begin
          st_d   = M_ACK;
          cap_en = 1'b1;
        end
      end
      M_ACK:    if (!req_s) st_d = M_ACCESS;
      M_ACCESS: begin
        if (cnt_q == '0 && !ack_s) begin
          st_d    = M_DATA;
          data_en = 1'b1;
        end
      end
      M_DATA:   if (ack_s)  st_d = M_DONE;
      M_DONE:   if (!ack_s) st_d = M_IDLE;
      default:  st_d = M_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      ack_q <= 1'b0;
      rdy_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= (st_d == M_ACK);
      rdy_q <= (st_d == M_DATA);
      oe_q  <= (st_d == M_DATA);
    end
  end

  // access timer, started when the address is captured
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cap_en)       cnt_q <= CW'(ACC_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      maddr_q <= '0;
    else if (cap_en) maddr_q <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mem_rdata_i;
  end

  assign rdy_o      = rdy_q;
  assign ack_o      = ack_q;
  assign oe_o       = oe_q;
  assign drv_o      = data_q;
  assign mem_addr_o = maddr_q;

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q && req_s |=> ack_q); // R4
  AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && !ack_s |=> rdy_q); // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && $past(rdy_q) |-> $stable(drv_o)); // R5
  AST_ACCESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> (cnt_q == '0)); // R5
endmodule

// File: rtl/hsb_read_link.sv
module hsb_read_link #(
  parameter int DW          = 32,
  parameter int ACC_CYC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_req,
  input  logic          clk_mem,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          readreq_o,
  output logic          datardy_o,
  output logic          ack_o,
  output logic [DW-1:0] bus_o
);
  logic          rst_req_n, rst_mem_n;
  logic          req_line, rdy_line, ack_line;
  logic          rq_ack, mm_ack;
  logic          rq_oe, mm_oe;
  logic [DW-1:0] rq_drv, mm_drv, bus;

  hsb_rst_sync u_rst_req (.clk(clk_req), .rst_n(rst_n), .rst_n_o(rst_req_n));
  hsb_rst_sync u_rst_mem (.clk(clk_mem), .rst_n(rst_n), .rst_n_o(rst_mem_n));

  // shared lines: acknowledge is wired-OR, data lines select the owner
  assign ack_line = rq_ack | mm_ack;
  assign bus      = rq_oe ? rq_drv : (mm_oe ? mm_drv : '0);

  hsb_requester #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk        (clk_req),
    .rst_n      (rst_req_n),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .bus_i      (bus),
    .ack_line_i (ack_line),
    .rdy_line_i (rdy_line),
    .req_o      (req_line),
    .ack_o      (rq_ack),
    .oe_o       (rq_oe),
    .drv_o      (rq_drv),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
  );

  hsb_memside #(.DW(DW), .ACC_CYC(ACC_CYC), .SYNC_STAGES(SYNC_STAGES)) u_mem (
    .clk         (clk_mem),
    .rst_n       (rst_mem_n),
    .bus_i       (bus),
    .req_line_i  (req_line),
    .ack_line_i  (ack_line),
    .rdy_o       (rdy_line),
    .ack_o       (mm_ack),
    .oe_o        (mm_oe),
    .drv_o       (mm_drv),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i)
  );

  assign readreq_o = req_line;
  assign datardy_o = rdy_line;
  assign ack_o     = ack_line;
  assign bus_o     = bus;

  AST_ONE_OWNER_REQ: assert property (@(posedge clk_req) disable iff (!rst_req_n)
    !(rq_oe && mm_oe)); // R7
  AST_ONE_OWNER_MEM: assert property (@(posedge clk_mem) disable iff (!rst_mem_n)
    !(rq_oe && mm_oe)); // R7
  AST_OE_WITH_STROBE: assert property (@(posedge clk_req) disable iff (!rst_req_n)
    rq_oe |-> req_line); // R7
endmodule

// File: tb/tb_hsb_read_link.sv
`timescale 1ns/1ps
module tb_hsb_read_link;
  localparam int DW = 32;

  logic          clk_req = 1'b0, clk_mem = 1'b0, rst_n;
  logic          start_i;
  logic [DW-1:0] addr_i;
  logic          busy_o, done_o, readreq_o, datardy_o, ack_o;
  logic [DW-1:0] rdata_o, mem_addr_o, mem_rdata_i, bus_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] cur_addr = '0;
  bit mon_on = 0;
  int step = 0;

  always #4   clk_req = ~clk_req;   // 125 MHz
  always #5.5 clk_mem = ~clk_mem;

  function automatic logic [DW-1:0] mix(input logic [DW-1:0] a);
    return (a ^ 32'hA5C3_0F1E) * 32'h9E37_79B1 + 32'h0000_1357;
  endfunction

  assign mem_rdata_i = mix(mem_addr_o);

  hsb_read_link dut (
    .clk_req(clk_req), .clk_mem(clk_mem), .rst_n(rst_n),
    .start_i(start_i), .addr_i(addr_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .readreq_o(readreq_o), .datardy_o(datardy_o), .ack_o(ack_o), .bus_o(bus_o)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected control edge order (R6): signal id 0=strobe 1=ack 2=ready
  function automatic int exp_sig(input int s);
    case (s)
      0, 2: return 0;
      4, 6: return 2;
      default: return 1;
    endcase
  endfunction
  function automatic logic exp_lvl(input int s);
    return (s == 0 || s == 1 || s == 4 || s == 5);
  endfunction
  function automatic string step_req(input int s);
    case (s)
      0: return "R2";
      1, 3: return "R4";
      2: return "R3";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic p_req = 0, p_ack = 0, p_rdy = 0;
  always @(readreq_o or ack_o or datardy_o) begin
    if (mon_on) begin : watch
      int sid;
      logic lvl;
      sid = -1; lvl = 1'b0;
      if (readreq_o !== p_req)      begin sid = 0; lvl = readreq_o; end
      else if (ack_o !== p_ack)     begin sid = 1; lvl = ack_o; end
      else if (datardy_o !== p_rdy) begin sid = 2; lvl = datardy_o; end
      p_req = readreq_o; p_ack = ack_o; p_rdy = datardy_o;
      if (sid >= 0) begin
        int s;
        s = step;
        check(sid == exp_sig(s) && lvl == exp_lvl(s), {step_req(s), " edge order"},
              DW'(sid * 2 + int'(lvl)), DW'(exp_sig(s) * 2 + int'(exp_lvl(s))));
        step = (s + 1) % 8;
        #1;
        if (s == 0) check(bus_o == cur_addr, "R2 address on bus", bus_o, cur_addr);
        if (s == 2) check(bus_o == '0, "R3 bus released", bus_o, '0);
        if (s == 4) check(bus_o == mix(cur_addr), "R5 data on bus", bus_o, mix(cur_addr));
        if (s == 4) check(mem_addr_o == cur_addr, "R4 captured address", mem_addr_o, cur_addr);
        if (s == 6) check(bus_o == '0, "R7 bus released after data", bus_o, '0);
      end
    end
  end

  task automatic do_read(input logic [DW-1:0] a, input bit mid_start);
    @(negedge clk_req);
    cur_addr = a;
    start_i = 1'b1; addr_i = a;
    @(negedge clk_req);
    start_i = 1'b0; addr_i = ~a;
    check(busy_o == 1'b1, "R2 busy after start", DW'(busy_o), 1);
    if (mid_start) begin
      repeat (5) @(negedge clk_req);
      start_i = 1'b1; addr_i = a ^ 32'h0F0F_0F0F;   // R8 stray start
      @(negedge clk_req);
      start_i = 1'b0;
    end
    for (int i = 0; i < 400 && !done_o; i++) @(negedge clk_req);
    check(done_o == 1'b1, "R6 done pulse", DW'(done_o), 1);
    check(rdata_o == mix(a), "R6 read data", rdata_o, mix(a));
    @(negedge clk_req);
    check(done_o == 1'b0, "R6 done one cycle", DW'(done_o), 0);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0;
    repeat (3) @(negedge clk_req);
    check(readreq_o == 0 && datardy_o == 0 && ack_o == 0, "R1 lines in reset",
          DW'({readreq_o, datardy_o, ack_o}), 0);
    check(bus_o == '0 && busy_o == 0 && done_o == 0, "R1 bus and status in reset",
          bus_o, '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_req);
    check(readreq_o == 0 && ack_o == 0 && datardy_o == 0 && busy_o == 0 && bus_o == '0,
          "R1 idle after reset", bus_o, '0);
    mon_on = 1;

    // directed corners
    do_read(32'h0000_0000, 0);
    repeat (8) @(negedge clk_req);
    do_read(32'hFFFF_FFFF, 0);
    repeat (8) @(negedge clk_req);

    // R8: stray start while busy
    do_read(32'h1234_5678, 1);
    repeat (20) @(negedge clk_req);
    check(readreq_o == 0 && busy_o == 0, "R8 no second read", DW'({readreq_o, busy_o}), 0);

    // R9: start on the cycle right after done
    do_read(32'hCAFE_0001, 0);
    start_i = 1'b1; addr_i = 32'hDEAD_BEEF;
    @(negedge clk_req);
    start_i = 1'b0;
    for (int i = 0; i < 12; i++) begin
      check(readreq_o == 0 && busy_o == 0, "R9 gated start ignored",
            DW'({readreq_o, busy_o}), 0);
      @(negedge clk_req);
    end

    // random reads with random gaps
    for (int n = 0; n < 40; n++) begin
      do_read($urandom, 0);
      for (int g = 0; g < 4 + ($urandom % 8); g++) begin
        @(negedge clk_req);
        if (!readreq_o && !datardy_o)
          check(bus_o == '0, "R7 idle bus reads zero", bus_o, '0);
      end
    end
    repeat (10) @(negedge clk_req);
    check(step == 0, "R6 sequence complete", DW'(step), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule